// File: doc/BRIEF.md
# Password-Gated Write Protection Unit

This block guards a small set of safety-relevant control bits: the clock divider settings, the watchdog enable, and the power-down and slow-down enables. Software writes these bits only while the block raises its write-permit output. Software controls the permit through one 8-bit key register. A 5-bit key field sits in bits [7:3] and a 2-bit mode field sits in bits [1:0]. The protected registers themselves are outside this block. They qualify their own write strobes with the permit.

When the mode is 11, protection is armed, and two key values unlock and relock the protected bits. The unlock key is 10011, so the byte is 98h. The relock key is 10101, so the byte is A8h. An unlock opens a window of 32 clocks. The window closes by itself when the count runs out, and another unlock restarts the count. Neither of these keys alters the mode. The mode changes only on a write that carries the key 11000. Such a write loads bits [1:0] into the mode. Writing any mode other than 11 disarms protection, and the permit then stays high.

Top module: `pwp_guard`

## Requirements
- R1: After reset the mode reads 11, the window is closed and the write permit is low.
- R2: With the mode at 11, a key-register write whose key field [7:3] is 10011 raises the window and the permit from the next clock.
- R3: After an unlock write the window stays open for exactly the 32 clocks that follow it. A protected write sampled in the 32nd of those clocks is still permitted, and the window is closed in the clock after.
- R4: An unlock write while the window is open restarts the full 32-clock count.
- R5: With the mode at 11, a write whose key field is 10101 closes the window from the next clock.
- R6: Unlock and relock writes leave the mode unchanged, whatever their bits [1:0] hold.
- R7: A write whose key field is 11000 loads bits [1:0] into the mode in any mode, and it closes the window.
- R8: While the mode is not 11 the permit is high, and unlock and relock keys have no effect: after re-arming, the window is found closed.
- R9: Writes carrying any other key value change neither the mode nor the window, and the window keeps counting down.
- R10: Data presented without the write strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_wr | input | 1 | Write strobe for the key register |
| key_wdata | input | 8 | Written byte: key field [7:3], mode field [1:0] |
| prot_wr_ok | output | 1 | Permit for writes to the protected bits |
| mode_q | output | 2 | Current mode; 11 means armed |
| win_open | output | 1 | Unlock window is open |

## Verification
The bench walks the window to its last permitted clock and to the clock after it. A design that is off by one would cut the 32nd clock or grant a 33rd. The bench also unlocks again partway through the window. A design that ignores the second unlock would close early. Unlock and relock bytes are sent with assorted low bits, which catches a design that lets them reach the mode. Unlocks sent while disarmed catch a design that still opens a window, because that window would show after re-arming. Random strobes mixed with the keys and stray bytes push the state into orderings that the directed steps do not reach.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
   // decoded key-register command, one bit per recognised key
   typedef struct packed {
      logic key_hit;    // mode-change key
      logic close_hit;  // relock key
      logic open_hit;   // unlock key
   } pwp_cmd_t;

   localparam int unsigned PWP_NKEYS = 3;
endpackage

// File: rtl/pwp_decode.sv
module pwp_decode
   import pwp_pkg::*;
#(
   parameter int unsigned          DATA_W    = 8,
   parameter int unsigned          PASS_W    = 5,
   parameter int unsigned          PASS_LSB  = 3,
   parameter logic [PASS_W-1:0]    OPEN_KEY  = 5'b10011,
   parameter logic [PASS_W-1:0]    CLOSE_KEY = 5'b10101,
   parameter logic [PASS_W-1:0]    MODE_KEY  = 5'b11000
) (
   input  logic              wr,
   input  logic [DATA_W-1:0] data,
   output pwp_cmd_t          cmd
);
   localparam logic [PWP_NKEYS*PASS_W-1:0] KEY_VEC = {MODE_KEY, CLOSE_KEY, OPEN_KEY};

   if (PASS_LSB + PASS_W > DATA_W) begin : g_bad_field
      $error("key field does not fit in the data word");
   end
   if (OPEN_KEY == CLOSE_KEY || OPEN_KEY == MODE_KEY || CLOSE_KEY == MODE_KEY) begin : g_bad_keys
      $error("key values must be distinct");
   end

   logic [PASS_W-1:0]    pass;
   logic [PWP_NKEYS-1:0] hit;

   assign pass = data[PASS_LSB +: PASS_W];

   for (genvar i = 0; i < PWP_NKEYS; i++) begin : g_cmp
      assign hit[i] = wr && (pass == KEY_VEC[i*PASS_W +: PASS_W]);
   end

   assign cmd.open_hit  = hit[0];
   assign cmd.close_hit = hit[1];
   assign cmd.key_hit   = hit[2];
endmodule

// File: rtl/pwp_mode_reg.sv
module pwp_mode_reg #(
   parameter int unsigned        DATA_W   = 8,
   parameter int unsigned        MODE_W   = 2,
   parameter int unsigned        MODE_LSB = 0,
   parameter logic [MODE_W-1:0]  MODE_RST = 2'b11,
   parameter logic [MODE_W-1:0]  MODE_ON  = 2'b11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   output logic [MODE_W-1:0] mode_q,
   output logic              armed
);
   if (MODE_LSB + MODE_W > DATA_W) begin : g_bad_mode
      $error("mode field does not fit in the data word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mode_q <= MODE_RST;
      else if (load) mode_q <= data[MODE_LSB +: MODE_W];
   end

   assign armed = (mode_q == MODE_ON);
endmodule

// File: rtl/pwp_window.sv
module pwp_window #(
   parameter int unsigned WIN_CYCLES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   output logic open
);
   if (WIN_CYCLES < 1) begin : g_bad_win
      $error("window must be at least one clock");
   end

   if (WIN_CYCLES == 1) begin : g_flag
      // single-clock window: a flag is enough
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     flag_q <= 1'b0;
         else if (stop)  flag_q <= 1'b0;
         else            flag_q <= start;
      end
      assign open = flag_q;
   end else begin : g_count
      localparam int unsigned CW   = $clog2(WIN_CYCLES + 1);
      localparam logic [CW-1:0] LOAD = CW'(WIN_CYCLES);
      logic [CW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              left_q <= '0;
         else if (stop)           left_q <= '0;
         else if (start)          left_q <= LOAD;
         else if (left_q != '0)   left_q <= left_q - 1'b1;
      end
      assign open = (left_q != '0);
   end
endmodule

// File: rtl/pwp_guard.sv
module pwp_guard
   import pwp_pkg::*;
#(
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       PASS_W     = 5,
   parameter int unsigned       PASS_LSB   = 3,
   parameter int unsigned       MODE_W     = 2,
   parameter int unsigned       MODE_LSB   = 0,
   parameter logic [PASS_W-1:0] OPEN_KEY   = 5'b10011,
   parameter logic [PASS_W-1:0] CLOSE_KEY  = 5'b10101,
   parameter logic [PASS_W-1:0] MODE_KEY   = 5'b11000,
   parameter logic [MODE_W-1:0] MODE_ON    = 2'b11,
   parameter int unsigned       WIN_CYCLES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] key_wdata,
   output logic              prot_wr_ok,
   output logic [MODE_W-1:0] mode_q,
   output logic              win_open
);
   pwp_cmd_t cmd;
   logic     armed;
   logic     win_start;
   logic     win_stop;

   pwp_decode #(
      .DATA_W(DATA_W), .PASS_W(PASS_W), .PASS_LSB(PASS_LSB),
      .OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY), .MODE_KEY(MODE_KEY)
   ) u_dec (
      .wr(key_wr), .data(key_wdata), .cmd(cmd)
   );

   pwp_mode_reg #(
      .DATA_W(DATA_W), .MODE_W(MODE_W), .MODE_LSB(MODE_LSB),
      .MODE_RST(MODE_ON), .MODE_ON(MODE_ON)
   ) u_mode (
      .clk(clk), .rst_n(rst_n), .load(cmd.key_hit), .data(key_wdata),
      .mode_q(mode_q), .armed(armed)
   );

   // keys act only while armed; a mode change always shuts the window
   assign win_start = cmd.open_hit && armed;
   assign win_stop  = (cmd.close_hit && armed) || cmd.key_hit;

   pwp_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
      .clk(clk), .rst_n(rst_n), .start(win_start), .stop(win_stop), .open(win_open)
   );

   assign prot_wr_ok = !armed || win_open;
endmodule

// File: rtl/pwp_guard_chk.sv
module pwp_guard_chk #(
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       PASS_W     = 5,
   parameter int unsigned       PASS_LSB   = 3,
   parameter int unsigned       MODE_W     = 2,
   parameter int unsigned       MODE_LSB   = 0,
   parameter logic [PASS_W-1:0] OPEN_KEY   = 5'b10011,
   parameter logic [PASS_W-1:0] CLOSE_KEY  = 5'b10101,
   parameter logic [PASS_W-1:0] MODE_KEY   = 5'b11000,
   parameter logic [MODE_W-1:0] MODE_ON    = 2'b11,
   parameter int unsigned       WIN_CYCLES = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              key_wr,
   input logic [DATA_W-1:0] key_wdata,
   input logic              prot_wr_ok,
   input logic [MODE_W-1:0] mode_q,
   input logic              win_open
);
   localparam int unsigned RW = $clog2(WIN_CYCLES + 2) + 1;
   localparam logic [RW-1:0] RMAX = RW'(WIN_CYCLES + 1);

   logic [PASS_W-1:0] pass;
   logic              armed_now;
   logic [RW-1:0]     run_q;

   assign pass      = key_wdata[PASS_LSB +: PASS_W];
   assign armed_now = (mode_q == MODE_ON);

   // open clocks since the last accepted unlock, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     run_q <= '0;
      else if (key_wr && armed_now && pass == OPEN_KEY) run_q <= RW'(1);
      else if (win_open && run_q != RMAX)             run_q <= run_q + 1'b1;
      else if (!win_open)                             run_q <= '0;
   end

   p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr && armed_now && pass == OPEN_KEY |=> win_open);

   p_win_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      win_open |-> (run_q >= RW'(1) && run_q <= RW'(WIN_CYCLES)));

   p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr && armed_now && pass == CLOSE_KEY |=> !win_open);

   p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(key_wr && pass == MODE_KEY) |=> $stable(mode_q));

   p_mode_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr && pass == MODE_KEY |=> (mode_q == $past(key_wdata[MODE_LSB +: MODE_W]) && !win_open));

   p_disarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_now |-> prot_wr_ok);

   p_armed_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      armed_now |-> (prot_wr_ok == win_open));
endmodule

bind pwp_guard pwp_guard_chk #(
   .DATA_W(DATA_W), .PASS_W(PASS_W), .PASS_LSB(PASS_LSB),
   .MODE_W(MODE_W), .MODE_LSB(MODE_LSB),
   .OPEN_KEY(OPEN_KEY), .CLOSE_KEY(CLOSE_KEY), .MODE_KEY(MODE_KEY),
   .MODE_ON(MODE_ON), .WIN_CYCLES(WIN_CYCLES)
) u_pwp_chk (
   .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_wdata(key_wdata),
   .prot_wr_ok(prot_wr_ok), .mode_q(mode_q), .win_open(win_open)
);

// File: tb/pwp_guard_bench.sv
module pwp_guard_bench;
   localparam int WIN = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_wr = 1'b0;
   logic [7:0] key_wdata = 8'h00;
   logic       prot_wr_ok;
   logic [1:0] mode_q;
   logic       win_open;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   // bench model
   logic [1:0] m_mode;
   int         m_left;

   always #4 clk = ~clk;   // 125 MHz

   pwp_guard u_pwp_guard (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_wdata(key_wdata),
      .prot_wr_ok(prot_wr_ok), .mode_q(mode_q), .win_open(win_open)
   );

   function automatic bit exp_ok();
      return (m_mode != 2'b11) || (m_left != 0);
   endfunction

   function automatic void model_edge(input logic w, input logic [7:0] d);
      logic [4:0] p;
      p = d[7:3];
      if (w && p == 5'b11000) begin
         m_mode = d[1:0];
         m_left = 0;
      end else if (w && m_mode == 2'b11 && p == 5'b10011) begin
         m_left = WIN;
      end else if (w && m_mode == 2'b11 && p == 5'b10101) begin
         m_left = 0;
      end else if (m_left != 0) begin
         m_left = m_left - 1;
      end
   endfunction

   task automatic check(input string tag);
      vectors++;
      if (prot_wr_ok !== exp_ok() || mode_q !== m_mode || win_open !== (m_left != 0)) begin
         miscompares++;
         $display("FAIL %s: ok/mode/open actual %b/%b/%b expected %b/%b/%b", tag,
                  prot_wr_ok, mode_q, win_open, exp_ok(), m_mode, (m_left != 0));
      end
   endtask

   // drive at the falling edge, model at the rising edge, check at the next fall
   task automatic step(input logic w, input logic [7:0] d, input string tag);
      key_wr    = w;
      key_wdata = d;
      @(posedge clk);
      model_edge(w, d);
      @(negedge clk);
      key_wr = 1'b0;
      check(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, tag);
   endtask

   initial begin
      m_mode = 2'b11;
      m_left = 0;
      repeat (3) @(negedge clk);
      check("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release");

      // R2 / R3: open then run the window out
      step(1'b1, 8'h98, "R2 open");
      idle(30, "R3 window");
      step(1'b0, 8'h00, "R3 last permitted clock");
      step(1'b0, 8'h00, "R3 closed after 32");

      // R4: reopen midway
      step(1'b1, 8'h98, "R4 open");
      idle(20, "R4 run");
      step(1'b1, 8'h98, "R4 reopen");
      idle(31, "R4 restarted count");
      step(1'b0, 8'h00, "R4 closed");

      // R5 / R6: close early, low bits varied
      step(1'b1, 8'h9A, "R6 open with low bits 10");
      idle(5, "R5 before close");
      step(1'b1, 8'hA9, "R5 close with low bits 01");
      step(1'b1, 8'hA8, "R6 close again");

      // R10: data without strobe
      step(1'b0, 8'h98, "R10 no strobe open");
      step(1'b0, 8'hC0, "R10 no strobe mode");

      // R9: stray keys while open
      step(1'b1, 8'h98, "R9 open");
      step(1'b1, 8'h00, "R9 stray 00");
      step(1'b1, 8'hFF, "R9 stray FF");
      step(1'b1, 8'hC8, "R9 near key");

      // R7: mode change closes window and disarms
      step(1'b1, 8'hC1, "R7 mode to 01");
      step(1'b1, 8'h98, "R8 open ignored");
      step(1'b1, 8'hA8, "R8 close ignored");
      step(1'b1, 8'hC2, "R7 mode to 10");
      step(1'b1, 8'hC3, "R8 rearm, window closed");
      step(1'b1, 8'h98, "R2 open after rearm");
      step(1'b1, 8'hC3, "R7 rewrite 11 closes window");

      // constrained random
      begin
         int unsigned seed_val;
         seed_val = $urandom(32'h5eed_1234);
         for (int i = 0; i < 3000; i++) begin
            logic [7:0] d;
            logic       w;
            int         sel;
            sel = int'($urandom_range(0, 9));
            case (sel)
               0, 1, 2: d = {5'b10011, 1'b0, 2'($urandom_range(0, 3))};
               3, 4:    d = {5'b10101, 1'b0, 2'($urandom_range(0, 3))};
               5:       d = {5'b11000, 1'b0, ($urandom_range(0, 3) != 0) ? 2'b11 : 2'($urandom_range(0, 2))};
               default: d = 8'($urandom);
            endcase
            w = ($urandom_range(0, 3) != 0);
            step(w, d, "R9 random mix");
         end
      end

      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #(8 * 190000);
      if (!finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule